// File: doc/BRIEF.md
# Clock-Enable Suspend and Power-Down Controller

This block sits beside the burst engine of a synchronous DRAM device and interprets the external clock-enable pin. Clock-enable is registered once, and every decision uses the registered copy. When the registered copy goes low while a read or write burst is running, the controller holds the burst in place. It drops the engine's advance enable, freezes the data bus and refuses new commands. When clock-enable falls with no burst running, the controller enters power-down instead.

On power-down entry the controller records two things. The first is whether every bank was precharged, which allows minimum-power operation. The second is whether a self-refresh command arrived in the same cycle as the clock-enable fall, which keeps the stored data alive. The two exits have different latencies. A held burst starts moving again one cycle later than power-down begins taking commands. This preserves the rule that a suspended burst resumes on the second edge, while a sleeping device listens on the first edge.

All timing below is counted in rising clock edges. "Edge k" is the edge that samples a new value on `cke_i`. An output described "after edge n" is valid during the cycle that follows edge n.

Top module: `clk_enable_pm_ctrl`

## Requirements
- R1: During and right after reset, the controller is in run mode: `adv_en_o`=1, `cmd_accept_o`=1, `dq_freeze_o`=0, `pd_active_o`=0, `pd_min_power_o`=0, `self_refresh_o`=0.
- R2: If `cke_i` is sampled low at edge k while `burst_busy_i`=1, then after edge k `adv_en_o`=0, `dq_freeze_o`=1 and `cmd_accept_o`=0. No output changes before edge k.
- R3: While `cke_i` stays low in a held burst, every cycle shows `adv_en_o`=0, `dq_freeze_o`=1, `cmd_accept_o`=0 and `pd_active_o`=0, so the burst beat and address cannot move.
- R4: If `cke_i` is sampled high at edge m in a held burst, the outputs stay at `adv_en_o`=0 and `dq_freeze_o`=1 after edge m. After edge m+1 they become `adv_en_o`=1, `dq_freeze_o`=0 and `cmd_accept_o`=1.
- R5: If `cke_i` is sampled low at edge k while `burst_busy_i`=0, then after edge k `cmd_accept_o`=0, `adv_en_o`=0 and `dq_freeze_o`=0, and after edge k+1 `pd_active_o`=1.
- R6: `pd_min_power_o` is 1 during a power-down only if `bank_active_i` (one bit per bank, 1 = row open) was all zeros at the entry edge k+1. The value holds for the whole power-down, whatever `bank_active_i` does later.
- R7: `self_refresh_o` is 1 during a power-down only if `srf_req_i` was 1 at edge k, the same edge that first sampled `cke_i` low. A request at any other edge leaves it 0.
- R8: If `cke_i` is sampled high at edge m in power-down, `cmd_accept_o`=1 after edge m. After edge m+1, `pd_active_o`, `pd_min_power_o` and `self_refresh_o` are 0 and `adv_en_o`=1.
- R9: A one-cycle high pulse on `cke_i` during a held burst never gives a cycle with `adv_en_o`=1. The burst stays frozen and is held again.
- R10: While `cke_i` is high in run mode, `bank_active_i`, `srf_req_i` and `burst_busy_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | External clock-enable level |
| burst_busy_i | input | 1 | A read or write burst is in progress |
| bank_active_i | input | NUM_BANKS | Per-bank row-open status, 1 = open |
| srf_req_i | input | 1 | Self-refresh command decoded this cycle |
| adv_en_o | output | 1 | Advance enable for the burst engine |
| cmd_accept_o | output | 1 | Command decoder may take a command |
| dq_freeze_o | output | 1 | Hold the data bus at its present state |
| pd_active_o | output | 1 | Device is in power-down |
| pd_min_power_o | output | 1 | Power-down with all banks precharged |
| self_refresh_o | output | 1 | Power-down was entered together with self-refresh |

## Verification
Outputs that depend only on registered clock-enable change one edge after `cke_i` is sampled: hold entry, refusal of commands, and acceptance on power-down exit. The mode-driven outputs change one edge later: `pd_active_o`, the recorded entry flags, and burst resumption. That gives the one-cycle gap between the two exits. The driver applies inputs at the falling edge and queues, for each applied cycle, the outputs due after the next rising edge. The monitor pops that entry one nanosecond after the rising edge, so every check lands on the exact edge count given in the requirements.

// File: rtl/ckepd_pkg.sv
package ckepd_pkg;

   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_HOLD  = 2'd1,
      MODE_SLEEP = 2'd2
   } mode_e;

endpackage

// File: rtl/ckepd_sample.sv
module ckepd_sample #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cke_i,
   input  logic srf_i,
   output logic cke_q,
   output logic srf_q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("ckepd_sample: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cke_q <= 1'b1;
               srf_q <= 1'b0;
            end else begin
               cke_q <= cke_i;
               srf_q <= srf_i;
            end
         end
      end else begin : g_chain
         logic [STAGES-1:0] cke_sr;
         logic [STAGES-1:0] srf_sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cke_sr <= '1;
               srf_sr <= '0;
            end else begin
               cke_sr <= {cke_sr[STAGES-2:0], cke_i};
               srf_sr <= {srf_sr[STAGES-2:0], srf_i};
            end
         end
         assign cke_q = cke_sr[STAGES-1];
         assign srf_q = srf_sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ckepd_fsm.sv
module ckepd_fsm
   import ckepd_pkg::*;
#(
   parameter int NUM_BANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke_q,
   input  logic                 srf_q,
   input  logic                 burst_busy_i,
   input  logic [NUM_BANKS-1:0] bank_active_i,
   output mode_e                mode_o,
   output logic                 idle_at_entry_o,
   output logic                 srf_at_entry_o
);

   mode_e mode_q, mode_d;
   logic  all_idle;
   logic  enter_sleep;

   assign all_idle    = ~|bank_active_i;
   assign enter_sleep = (mode_q == MODE_RUN) && !cke_q && !burst_busy_i;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_RUN: begin
            if (!cke_q) mode_d = burst_busy_i ? MODE_HOLD : MODE_SLEEP;
         end
         MODE_HOLD: begin
            if (cke_q) mode_d = MODE_RUN;
         end
         MODE_SLEEP: begin
            if (cke_q) mode_d = MODE_RUN;
         end
         default: mode_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q          <= MODE_RUN;
         idle_at_entry_o <= 1'b0;
         srf_at_entry_o  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (enter_sleep) begin
            idle_at_entry_o <= all_idle;
            srf_at_entry_o  <= srf_q;
         end else if (mode_d != MODE_SLEEP) begin
            idle_at_entry_o <= 1'b0;
            srf_at_entry_o  <= 1'b0;
         end
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/ckepd_outdec.sv
module ckepd_outdec
   import ckepd_pkg::*;
(
   input  mode_e mode_i,
   input  logic  cke_q,
   input  logic  burst_busy_i,
   input  logic  idle_at_entry_i,
   input  logic  srf_at_entry_i,
   output logic  adv_en_o,
   output logic  cmd_accept_o,
   output logic  dq_freeze_o,
   output logic  pd_active_o,
   output logic  pd_min_power_o,
   output logic  self_refresh_o
);

   always_comb begin
      adv_en_o       = 1'b0;
      cmd_accept_o   = 1'b0;
      dq_freeze_o    = 1'b0;
      pd_active_o    = 1'b0;
      pd_min_power_o = 1'b0;
      self_refresh_o = 1'b0;
      unique case (mode_i)
         MODE_RUN: begin
            adv_en_o     = cke_q;
            cmd_accept_o = cke_q;
            dq_freeze_o  = !cke_q && burst_busy_i;
         end
         MODE_HOLD: begin
            dq_freeze_o  = 1'b1;
         end
         MODE_SLEEP: begin
            cmd_accept_o   = cke_q;
            pd_active_o    = 1'b1;
            pd_min_power_o = idle_at_entry_i;
            self_refresh_o = srf_at_entry_i;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/clk_enable_pm_ctrl.sv
module clk_enable_pm_ctrl
   import ckepd_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int CKE_STAGES = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke_i,
   input  logic                 burst_busy_i,
   input  logic [NUM_BANKS-1:0] bank_active_i,
   input  logic                 srf_req_i,
   output logic                 adv_en_o,
   output logic                 cmd_accept_o,
   output logic                 dq_freeze_o,
   output logic                 pd_active_o,
   output logic                 pd_min_power_o,
   output logic                 self_refresh_o
);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 64) begin : g_bad_banks
         $error("clk_enable_pm_ctrl: NUM_BANKS out of range");
      end
   endgenerate

   logic  cke_q;
   logic  srf_q;
   mode_e mode;
   logic  idle_at_entry;
   logic  srf_at_entry;

   ckepd_sample #(.STAGES(CKE_STAGES)) u_sample (
      .clk   (clk),
      .rst_n (rst_n),
      .cke_i (cke_i),
      .srf_i (srf_req_i),
      .cke_q (cke_q),
      .srf_q (srf_q)
   );

   ckepd_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .cke_q           (cke_q),
      .srf_q           (srf_q),
      .burst_busy_i    (burst_busy_i),
      .bank_active_i   (bank_active_i),
      .mode_o          (mode),
      .idle_at_entry_o (idle_at_entry),
      .srf_at_entry_o  (srf_at_entry)
   );

   ckepd_outdec u_dec (
      .mode_i          (mode),
      .cke_q           (cke_q),
      .burst_busy_i    (burst_busy_i),
      .idle_at_entry_i (idle_at_entry),
      .srf_at_entry_i  (srf_at_entry),
      .adv_en_o        (adv_en_o),
      .cmd_accept_o    (cmd_accept_o),
      .dq_freeze_o     (dq_freeze_o),
      .pd_active_o     (pd_active_o),
      .pd_min_power_o  (pd_min_power_o),
      .self_refresh_o  (self_refresh_o)
   );

endmodule

// File: rtl/ckepd_checker.sv
module ckepd_checker
   import ckepd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cke_q,
   input logic [1:0] mode,
   input logic       adv_en_o,
   input logic       cmd_accept_o,
   input logic       dq_freeze_o,
   input logic       pd_active_o,
   input logic       pd_min_power_o,
   input logic       self_refresh_o
);

   AST_FREEZE_BLOCKS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      dq_freeze_o |-> (!adv_en_o && !cmd_accept_o)); // R3

   AST_RESUME_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD && cke_q) |-> !adv_en_o); // R4

   AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD && cke_q) |=> (mode == MODE_RUN)); // R4

   AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_active_o && !cke_q) |-> !cmd_accept_o); // R5

   AST_MINPWR_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
      pd_min_power_o |-> pd_active_o); // R6

   AST_SRF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_active_o && $past(pd_active_o)) |-> $stable(self_refresh_o)); // R7

   AST_WAKE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SLEEP && cke_q) |-> cmd_accept_o); // R8

   AST_SUSPEND_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD) |-> !pd_active_o); // R3

endmodule

bind clk_enable_pm_ctrl ckepd_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cke_q          (cke_q),
   .mode           (mode),
   .adv_en_o       (adv_en_o),
   .cmd_accept_o   (cmd_accept_o),
   .dq_freeze_o    (dq_freeze_o),
   .pd_active_o    (pd_active_o),
   .pd_min_power_o (pd_min_power_o),
   .self_refresh_o (self_refresh_o)
);

// File: tb/tb_clk_enable_pm_ctrl.sv
`timescale 1ns/1ps
module tb_clk_enable_pm_ctrl;

   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_i = 1'b1;
   logic          burst_busy_i = 1'b0;
   logic [NB-1:0] bank_active_i = '0;
   logic          srf_req_i = 1'b0;
   logic adv_en_o, cmd_accept_o, dq_freeze_o, pd_active_o, pd_min_power_o, self_refresh_o;

   clk_enable_pm_ctrl #(.NUM_BANKS(NB), .CKE_STAGES(1)) dut (
      .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .burst_busy_i(burst_busy_i),
      .bank_active_i(bank_active_i), .srf_req_i(srf_req_i),
      .adv_en_o(adv_en_o), .cmd_accept_o(cmd_accept_o), .dq_freeze_o(dq_freeze_o),
      .pd_active_o(pd_active_o), .pd_min_power_o(pd_min_power_o),
      .self_refresh_o(self_refresh_o)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic [5:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // vector order: {adv, accept, freeze, pd, minpwr, selfref}
   function automatic logic [5:0] outs();
      return {adv_en_o, cmd_accept_o, dq_freeze_o, pd_active_o, pd_min_power_o, self_refresh_o};
   endfunction

   task automatic compare(input logic [5:0] exp, input string tag);
      checks++;
      if (outs() !== exp) begin
         errors++;
         $display("FAIL %s: actual adv/acc/frz/pd/min/sr=%b expected=%b", tag, outs(), exp);
      end
   endtask

   task automatic step(input logic cke, input logic busy, input logic [NB-1:0] banks,
                       input logic srf, input logic [5:0] exp, input string tag);
      @(negedge clk);
      cke_i = cke;
      burst_busy_i = busy;
      bank_active_i = banks;
      srf_req_i = srf;
      q.push_back('{exp: exp, tag: tag});
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            compare(it.exp, it.tag);
         end
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      compare(6'b110000, "R1 during reset");
      rst_n = 1'b1;
      #1;
      compare(6'b110000, "R1 after reset");

      // R10: run mode ignores status inputs while clock-enable is high
      step(1, 1, 4'b0000, 1, 6'b110000, "R10 srf/banks ignored");
      step(1, 0, 4'b1111, 0, 6'b110000, "R10 busy ignored");

      // held burst: R2 entry, R3 hold, R4 resume on second edge
      step(0, 1, 4'b0001, 0, 6'b001000, "R2 hold entry");
      step(0, 1, 4'b0001, 0, 6'b001000, "R3 hold");
      step(0, 1, 4'b0001, 0, 6'b001000, "R3 hold");
      step(1, 1, 4'b0001, 0, 6'b001000, "R4 first edge still frozen");
      step(1, 1, 4'b0001, 0, 6'b110000, "R4 resumed");

      // R9: single-cycle clock-enable pulse in a hold
      step(0, 1, 4'b0001, 0, 6'b001000, "R9 entry");
      step(0, 1, 4'b0001, 0, 6'b001000, "R9 hold");
      step(1, 1, 4'b0001, 0, 6'b001000, "R9 pulse");
      step(0, 1, 4'b0001, 0, 6'b001000, "R9 no advance");
      step(0, 1, 4'b0001, 0, 6'b001000, "R9 held again");
      step(1, 1, 4'b0001, 0, 6'b001000, "R9 exit first edge");
      step(1, 0, 4'b0001, 0, 6'b110000, "R9 exit resumed");

      // power-down, all idle, self-refresh with entry: R5 R6 R7 R8
      step(0, 0, 4'b0000, 1, 6'b000000, "R5 accept drops");
      step(0, 0, 4'b0000, 0, 6'b000111, "R5 R6 R7 pd entered");
      step(0, 0, 4'b0100, 0, 6'b000111, "R6 flag latched");
      step(1, 0, 4'b0100, 0, 6'b010111, "R8 accept on first edge");
      step(1, 0, 4'b0100, 0, 6'b110000, "R8 pd left");

      // power-down with a bank open, late self-refresh request: R6 R7
      step(0, 0, 4'b0010, 0, 6'b000000, "R5 accept drops");
      step(0, 0, 4'b0010, 1, 6'b000100, "R6 R7 no minpwr no sr");
      step(0, 0, 4'b0000, 1, 6'b000100, "R7 late request ignored");
      step(1, 0, 4'b0000, 0, 6'b010100, "R8 accept on first edge");
      step(1, 0, 4'b0000, 0, 6'b110000, "R8 pd left");

      @(posedge clk);
      #2;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (2000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual run still going expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule